// File: doc/BRIEF.md
# Dual-Bank Scratchpad Access Arbiter

This block decides, cycle by cycle, which of four requesters may touch two on-chip scratchpad banks (X and Y), each divided into pages. A fast local port and a slow system-side port accept 8-, 16- and 32-bit accesses anywhere in the scratchpad. Two dedicated 16-bit data ports reach only their own bank: the X port reaches bank X and the Y port reaches bank Y. The block holds no data. It produces ready, error, byte-lane and write-strobe signals, and the memory datapath next to it acts on them.

Requests are level signals that are held until ready. Outputs follow the inputs within the same cycle. The only state is the system port's latency counter. When two requests in one cycle name the same bank and the same page, the lower-priority request waits. The priority order is the dedicated ports first, then the local port, then the system port. Each local or system access is also checked against the processor mode (privileged bit, DSP-enable bit), the address region, the access width and the alignment. An access that fails is rejected at once with an error.

Address layout for the local and system ports, with default parameters and a 16-bit address:
- bits [15:14] give the region: 00 is the shared low region, 01 is the user DSP window, 10 is the privileged upper region, 11 is unmapped.
- bit 13 selects the bank: 0 is X, 1 is Y.
- bits [12:10] give the page.
- bits [1:0] select the byte lanes.

The dedicated ports present only a page index.

Top module: `xy_scratch_arb`

## Requirements
- R1: Access size is coded 0 = byte, 1 = halfword, 2 = word. The byte enables for an issued access are: byte gives 4'b0001 shifted left by addr[1:0]; halfword gives 4'b0011 when addr[1] = 0 and 4'b1100 when addr[1] = 1; word gives 4'b1111. When the access is not issued, the byte enables are 0.
- R2: These requests are rejected with an error: a halfword with addr[0] = 1, a word with addr[1:0] not equal to 0, and size code 3.
- R3: A valid local access with no page conflict is ready in the same cycle it is presented.
- R4: The X and Y ports are always ready in the cycle they request, including when both request together.
- R5: A local request is held (not ready) while the X or Y port uses its bank and page. A system request is held while the X port, the Y port or a valid local request uses its bank and page.
- R6: A valid system access waits SYS_WAIT cycles (default 3) before it becomes ready. If its page is taken by another port at that point, it keeps waiting until the page is free.
- R7: With the privileged bit set, only regions 00 and 10 are allowed.
- R8: With the privileged bit clear and the DSP-enable bit set, only regions 00 and 01 are allowed.
- R9: With both mode bits clear, only region 00 is allowed. A region 01 access is rejected.
- R10: A local or system request flagged as coming from the DSP with byte size is rejected. Halfword and word DSP requests are accepted.
- R11: A rejected access is ready in its first cycle with the error flag set, the write strobe low and the byte enables zero. This also applies to the system port.
- R12: While reset is asserted, the system latency counter stays cleared, so a held system request is not ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_priv | input | 1 | Privileged mode bit |
| mode_dsp | input | 1 | DSP-enable mode bit |
| lp_req | input | 1 | Local port request |
| lp_we | input | 1 | Local port write |
| lp_dsp | input | 1 | Local request issued by the DSP |
| lp_size | input | 2 | Local access size code |
| lp_addr | input | OFF_W+PAGE_W+3 | Local port address |
| lp_rdy | output | 1 | Local access completes this cycle |
| lp_err | output | 1 | Local access rejected |
| lp_be | output | 4 | Local byte enables |
| lp_wr | output | 1 | Local write strobe |
| sp_req | input | 1 | System port request |
| sp_we | input | 1 | System port write |
| sp_dsp | input | 1 | System request issued by the DSP |
| sp_size | input | 2 | System access size code |
| sp_addr | input | OFF_W+PAGE_W+3 | System port address |
| sp_rdy | output | 1 | System access completes this cycle |
| sp_err | output | 1 | System access rejected |
| sp_be | output | 4 | System byte enables |
| sp_wr | output | 1 | System write strobe |
| xp_req | input | 1 | X port request |
| xp_page | input | PAGE_W | X port page index |
| xp_rdy | output | 1 | X port access completes |
| yp_req | input | 1 | Y port request |
| yp_page | input | PAGE_W | Y port page index |
| yp_rdy | output | 1 | Y port access completes |

## Verification
Two things can happen in the same cycle: a page conflict, and the system port reaching the end of its wait. In that cycle the arbitration and the latency counter interact. The bench provokes this in two ways. It holds a local request on the system port's page across the cycle in which the system port becomes due. It also drives random traffic confined to a few pages, so that X, Y, local and system requests collide often. A behavioural model judges each cycle. The model tracks how long the system request has been held, and it expects the system port to stay waiting after its count expires until the page frees. It also expects a rejection that arrives mid-wait to complete at once.

// File: rtl/xy_scratch_arb.sv
module xy_scratch_arb #(
  parameter int OFF_W    = 10,
  parameter int PAGE_W   = 3,
  parameter int SYS_WAIT = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      mode_priv,
  input  logic                      mode_dsp,
  input  logic                      lp_req,
  input  logic                      lp_we,
  input  logic                      lp_dsp,
  input  logic [1:0]                lp_size,
  input  logic [OFF_W+PAGE_W+2:0]   lp_addr,
  output logic                      lp_rdy,
  output logic                      lp_err,
  output logic [3:0]                lp_be,
  output logic                      lp_wr,
  input  logic                      sp_req,
  input  logic                      sp_we,
  input  logic                      sp_dsp,
  input  logic [1:0]                sp_size,
  input  logic [OFF_W+PAGE_W+2:0]   sp_addr,
  output logic                      sp_rdy,
  output logic                      sp_err,
  output logic [3:0]                sp_be,
  output logic                      sp_wr,
  input  logic                      xp_req,
  input  logic [PAGE_W-1:0]         xp_page,
  output logic                      xp_rdy,
  input  logic                      yp_req,
  input  logic [PAGE_W-1:0]         yp_page,
  output logic                      yp_rdy
);
  localparam int AW    = OFF_W + PAGE_W + 3;
  localparam int BANK  = OFF_W + PAGE_W;
  localparam int KW    = PAGE_W + 1;
  localparam int CNT_W = $clog2(SYS_WAIT + 2);

  function automatic logic [3:0] lanes(input logic [1:0] sz, input logic [1:0] lo);
    case (sz)
      2'd0:    return 4'b0001 << lo;
      2'd1:    return lo[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic rejected(input logic [AW-1:0] a, input logic [1:0] sz,
                                    input logic dsp, input logic priv, input logic dspm);
    logic [1:0] rg;
    logic ok, mis;
    rg  = a[AW-1:AW-2];
    ok  = (rg == 2'b00) | (priv & rg == 2'b10) | (~priv & dspm & rg == 2'b01);
    mis = (sz == 2'd1 & a[0]) | (sz == 2'd2 & |a[1:0]) | (sz == 2'd3);
    return ~ok | mis | (dsp & sz == 2'd0);
  endfunction

  logic [KW-1:0] lp_key, sp_key, x_key, y_key;
  logic          lp_bad, sp_bad, lp_ok, lp_blk, sp_blk, lp_go, sp_go, sp_due;
  logic [CNT_W-1:0] sp_cnt;
  logic          unused_offset;

  assign lp_key = lp_addr[BANK:OFF_W];
  assign sp_key = sp_addr[BANK:OFF_W];
  assign x_key  = {1'b0, xp_page};
  assign y_key  = {1'b1, yp_page};
  assign unused_offset = ^{lp_addr[OFF_W-1:2], sp_addr[OFF_W-1:2]};

  assign lp_bad = lp_req & rejected(lp_addr, lp_size, lp_dsp, mode_priv, mode_dsp);
  assign sp_bad = sp_req & rejected(sp_addr, sp_size, sp_dsp, mode_priv, mode_dsp);
  assign lp_ok  = lp_req & ~lp_bad;

  assign lp_blk = (xp_req & lp_key == x_key) | (yp_req & lp_key == y_key);
  assign sp_blk = (xp_req & sp_key == x_key) | (yp_req & sp_key == y_key)
                | (lp_ok & lp_key == sp_key);

  assign xp_rdy = xp_req;
  assign yp_rdy = yp_req;

  assign lp_go  = lp_ok & ~lp_blk;
  assign lp_rdy = lp_bad | lp_go;
  assign lp_err = lp_bad;
  assign lp_be  = lp_go ? lanes(lp_size, lp_addr[1:0]) : 4'b0000;
  assign lp_wr  = lp_go & lp_we;

  assign sp_due = (sp_cnt == CNT_W'(SYS_WAIT));
  assign sp_go  = sp_req & ~sp_bad & sp_due & ~sp_blk;
  assign sp_rdy = sp_bad | sp_go;
  assign sp_err = sp_bad;
  assign sp_be  = sp_go ? lanes(sp_size, sp_addr[1:0]) : 4'b0000;
  assign sp_wr  = sp_go & sp_we;

  always_ff @(posedge clk) begin
    if (!rst_n || !sp_req || sp_rdy) sp_cnt <= '0;
    else if (!sp_due)                sp_cnt <= sp_cnt + 1'b1;
  end
endmodule

module xy_scratch_arb_chk #(
  parameter int OFF_W    = 10,
  parameter int PAGE_W   = 3,
  parameter int SYS_WAIT = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    mode_priv,
  input logic                    mode_dsp,
  input logic                    lp_req,
  input logic [OFF_W+PAGE_W+2:0] lp_addr,
  input logic                    lp_rdy,
  input logic                    lp_err,
  input logic [3:0]              lp_be,
  input logic                    lp_wr,
  input logic                    sp_req,
  input logic [OFF_W+PAGE_W+2:0] sp_addr,
  input logic                    sp_rdy,
  input logic                    sp_err,
  input logic [3:0]              sp_be,
  input logic                    sp_wr,
  input logic                    xp_req,
  input logic [PAGE_W-1:0]       xp_page,
  input logic                    xp_rdy,
  input logic                    yp_req,
  input logic                    yp_rdy
);
  localparam int AW = OFF_W + PAGE_W + 3;
  localparam int BANK = OFF_W + PAGE_W;
  logic [15:0] held;

  always_ff @(posedge clk) begin
    if (!rst_n || !sp_req || sp_rdy) held <= '0;
    else if (held != 16'hFFFF)       held <= held + 1'b1;
  end

  assert_xy_parallel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xp_req && yp_req) |-> (xp_rdy && yp_rdy));
  assert_sys_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_rdy && !sp_err) |-> (held >= 16'(SYS_WAIT)));
  assert_local_reject_R11: assert property (@(posedge clk) disable iff (!rst_n)
    lp_err |-> (lp_rdy && !lp_wr && lp_be == 4'b0000));
  assert_sys_reject_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sp_err |-> (sp_rdy && !sp_wr && sp_be == 4'b0000));
  assert_no_shared_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_rdy && !lp_err && sp_rdy && !sp_err) |-> (lp_addr[BANK:OFF_W] != sp_addr[BANK:OFF_W]));
  assert_x_wins_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xp_req && lp_req && !lp_err && !lp_addr[BANK] && lp_addr[BANK-1:OFF_W] == xp_page) |-> !lp_rdy);
  assert_user_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_req && !mode_priv && !mode_dsp && lp_addr[AW-1:AW-2] == 2'b01) |-> lp_err);
  assert_lane_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_rdy && !lp_err) |-> ($countones(lp_be) == 1 || $countones(lp_be) == 2 || $countones(lp_be) == 4));
endmodule

bind xy_scratch_arb xy_scratch_arb_chk #(.OFF_W(OFF_W), .PAGE_W(PAGE_W), .SYS_WAIT(SYS_WAIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_priv(mode_priv), .mode_dsp(mode_dsp),
  .lp_req(lp_req), .lp_addr(lp_addr), .lp_rdy(lp_rdy), .lp_err(lp_err), .lp_be(lp_be), .lp_wr(lp_wr),
  .sp_req(sp_req), .sp_addr(sp_addr), .sp_rdy(sp_rdy), .sp_err(sp_err), .sp_be(sp_be), .sp_wr(sp_wr),
  .xp_req(xp_req), .xp_page(xp_page), .xp_rdy(xp_rdy), .yp_req(yp_req), .yp_rdy(yp_rdy));

// File: tb/tb_xy_scratch_arb.sv
module tb_xy_scratch_arb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_priv = 1'b1, mode_dsp = 1'b0;
  logic lp_req = 0, lp_we = 0, lp_dsp = 0;
  logic [1:0] lp_size = 0;
  logic [15:0] lp_addr = 0;
  logic sp_req = 0, sp_we = 0, sp_dsp = 0;
  logic [1:0] sp_size = 0;
  logic [15:0] sp_addr = 0;
  logic xp_req = 0, yp_req = 0;
  logic [2:0] xp_page = 0, yp_page = 0;
  logic lp_rdy, lp_err, lp_wr, sp_rdy, sp_err, sp_wr, xp_rdy, yp_rdy;
  logic [3:0] lp_be, sp_be;

  int n_cmp = 0, n_bad = 0, mcnt = 0;
  bit done = 0, last_sp_rdy = 1;

  always #4 clk = ~clk;

  xy_scratch_arb dut (.*);

  function automatic logic [15:0] A(int rg, int bk, int pg, int off);
    return 16'((rg << 14) | (bk << 13) | (pg << 10) | off);
  endfunction

  function automatic bit bad(logic [15:0] a, logic [1:0] sz, logic dsp);
    int rg = int'(a >> 14);
    bit ok;
    ok = (rg == 0) || (mode_priv && rg == 2) || (!mode_priv && mode_dsp && rg == 1);
    if (!ok) return 1;
    if (sz == 3) return 1;
    if (sz == 1 && a[0]) return 1;
    if (sz == 2 && a[1:0] != 0) return 1;
    if (dsp && sz == 0) return 1;
    return 0;
  endfunction

  function automatic logic [3:0] be_of(logic [15:0] a, logic [1:0] sz);
    if (sz == 0) return 4'(1 << a[1:0]);
    if (sz == 1) return 4'(3 << a[1:0]);
    return 4'hF;
  endfunction

  function automatic bit xy_taken(int k);
    return (xp_req && k == int'(xp_page)) || (yp_req && k == 8 + int'(yp_page));
  endfunction

  function automatic logic [15:0] model();
    bit lb, sb, lgo, sgo;
    int lk, sk;
    lk = int'(lp_addr >> 10) & 15;
    sk = int'(sp_addr >> 10) & 15;
    lb = lp_req && bad(lp_addr, lp_size, lp_dsp);
    sb = sp_req && bad(sp_addr, sp_size, sp_dsp);
    lgo = lp_req && !lb && !xy_taken(lk);
    sgo = sp_req && !sb && mcnt >= 3 && !xy_taken(sk) && !(lp_req && !lb && lk == sk);
    return {xp_req, yp_req, lb | lgo, lb, lgo ? be_of(lp_addr, lp_size) : 4'h0, lgo & lp_we,
            sb | sgo, sb, sgo ? be_of(sp_addr, sp_size) : 4'h0, sgo & sp_we};
  endfunction

  task automatic cyc(input string tag);
    logic [15:0] e, a;
    #2;
    e = model();
    a = {xp_rdy, yp_rdy, lp_rdy, lp_err, lp_be, lp_wr, sp_rdy, sp_err, sp_be, sp_wr};
    n_cmp++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, a, e);
    end
    last_sp_rdy = e[6];
    @(posedge clk);
    if (!rst_n || !sp_req || e[6]) mcnt = 0;
    else if (mcnt < 3) mcnt++;
    @(negedge clk);
  endtask

  task automatic lp_set(logic r, logic w, logic d, logic [1:0] s, logic [15:0] a);
    lp_req = r; lp_we = w; lp_dsp = d; lp_size = s; lp_addr = a;
  endtask

  task automatic sp_set(logic r, logic w, logic d, logic [1:0] s, logic [15:0] a);
    sp_req = r; sp_we = w; sp_dsp = d; sp_size = s; sp_addr = a;
  endtask

  task automatic idle();
    lp_req = 0; sp_req = 0; xp_req = 0; yp_req = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    sp_set(1, 0, 0, 2, A(0, 0, 1, 0));
    repeat (5) cyc("R12 reset holds system counter");
    idle();
    rst_n = 1;
    cyc("R12 idle after reset");
    lp_set(1, 0, 0, 0, A(0, 0, 0, 1)); cyc("R1 byte lane 1");
    lp_set(1, 1, 0, 0, A(0, 1, 2, 3)); cyc("R1 byte lane 3 write");
    lp_set(1, 0, 0, 1, A(0, 0, 0, 2)); cyc("R1 upper half");
    lp_set(1, 1, 0, 2, A(0, 1, 5, 8)); cyc("R1 word");
    lp_set(1, 0, 0, 1, A(0, 0, 0, 1)); cyc("R2 misaligned half");
    lp_set(1, 0, 0, 2, A(0, 0, 0, 2)); cyc("R2 misaligned word");
    lp_set(1, 0, 0, 3, A(0, 0, 0, 0)); cyc("R2 bad size code");
    lp_set(1, 0, 0, 2, A(0, 1, 7, 4)); cyc("R3 local alone");
    xp_req = 1; yp_req = 1; xp_page = 3; yp_page = 3;
    lp_set(1, 0, 0, 2, A(0, 0, 4, 0)); cyc("R4 X and Y together");
    lp_set(1, 0, 0, 2, A(0, 0, 3, 0)); cyc("R5 local loses to X");
    lp_set(1, 1, 0, 2, A(0, 1, 3, 0)); cyc("R5 local loses to Y");
    yp_req = 0; cyc("R5 local released by Y");
    idle();
    sp_set(1, 1, 0, 2, A(0, 0, 2, 0));
    repeat (4) cyc("R6 system latency");
    cyc("R6 system idle after done");
    sp_set(0, 0, 0, 0, 0); cyc("R6 system dropped");
    sp_set(1, 0, 0, 1, A(0, 1, 6, 2));
    lp_set(1, 0, 0, 2, A(0, 1, 6, 0));
    repeat (5) cyc("R6 R5 system blocked at due cycle");
    lp_req = 0; cyc("R6 system completes when free");
    sp_req = 0; xp_req = 1; xp_page = 2;
    sp_set(1, 0, 0, 2, A(0, 0, 2, 0));
    repeat (4) cyc("R5 system loses to X");
    xp_req = 0; cyc("R5 system after X");
    idle();
    mode_priv = 1; mode_dsp = 0;
    for (int r = 0; r < 4; r++) begin
      lp_set(1, 1, 0, 2, A(r, 0, 0, 0)); cyc("R7 privileged region");
    end
    mode_priv = 0; mode_dsp = 1;
    for (int r = 0; r < 4; r++) begin
      lp_set(1, 1, 0, 2, A(r, 1, 1, 0)); cyc("R8 user dsp region");
    end
    mode_priv = 0; mode_dsp = 0;
    for (int r = 0; r < 4; r++) begin
      lp_set(1, 0, 0, 2, A(r, 0, 1, 0)); cyc("R9 user region");
    end
    mode_priv = 1;
    lp_set(1, 0, 1, 0, A(0, 0, 0, 0)); cyc("R10 dsp byte rejected");
    lp_set(1, 0, 1, 1, A(0, 0, 0, 2)); cyc("R10 dsp half accepted");
    lp_req = 0;
    sp_set(1, 1, 1, 0, A(0, 0, 0, 0)); cyc("R10 R11 dsp byte on system port");
    sp_req = 0;
    lp_set(1, 1, 0, 2, A(3, 0, 0, 0)); cyc("R11 rejected write");
    idle();
    sp_set(1, 1, 0, 2, A(0, 0, 1, 0));
    cyc("R11 system start");
    sp_addr = A(3, 0, 1, 0); cyc("R11 reject mid wait");
    idle(); cyc("R11 idle");
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 16) == 0) begin mode_priv = 1'($urandom); mode_dsp = 1'($urandom); end
      xp_req = 1'($urandom); yp_req = 1'($urandom);
      xp_page = 3'($urandom % 2); yp_page = 3'($urandom % 2);
      lp_set(1'($urandom), 1'($urandom), ($urandom % 4) == 0, 2'(($urandom % 8) == 0 ? 3 : $urandom % 3),
             A(($urandom % 4) == 0 ? $urandom % 4 : 0, $urandom % 2, $urandom % 2, $urandom % 1024));
      if (last_sp_rdy || !sp_req)
        sp_set(1'($urandom), 1'($urandom), ($urandom % 4) == 0, 2'($urandom % 3),
               A(($urandom % 6) == 0 ? $urandom % 4 : 0, $urandom % 2, $urandom % 2, 4 * ($urandom % 256)));
      cyc("R5 R6 random traffic");
    end
    done = 1;
    summary();
    $finish;
  end
endmodule